// File: doc/BRIEF.md
# Codec Power Management Controller

This block holds the eight power-enable bits of a stereo audio codec. It turns them into enable lines for the reference bias, the mic-bias pad, the two microphone amplifiers, the two ADC channels and the two DAC channels. A simple write port loads the power bits or acts on a status flag. A read port returns either the stored power bits or that flag. An active-low hardware power-down input acts as the asynchronous reset for the whole block. While it is low, every enable is off, and releasing it leaves all bits at their powered-down default.

A small state machine gates ADC data after a channel is switched on. It has three states. ADC_IDLE means no ADC channel is enabled. ADC_INIT means the initialization window is counting. ADC_READY means the ADC data is valid. The named transitions are:

- START: any ADC channel bit goes from 0 to 1. It moves from any state to ADC_INIT with the count at zero.
- STOP: a write leaves both ADC channel bits at 0. It moves from any state to ADC_IDLE.
- DONE: the last sample strobe of the window arrives. It moves from ADC_INIT to ADC_READY.

The window is counted in sample-rate strobes, 1059 by default. A sticky flag records any write that enables a block while leaving the reference bias off. A clock-request output tells the system when external converter clocks must be running.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After power-down is released, every enable output, `mic_bias_oe`, `adc_valid`, `clk_req` and `rd_data` is 0 until the first write.
- R2: A write with `wr_sel`=0 stores `wr_data`. The bit map is: bit 0 reference bias, bit 1 mic-bias pad, bit 2 mic amp left, bit 3 mic amp right, bit 4 ADC left, bit 5 ADC right, bit 6 DAC left, bit 7 DAC right. From the next cycle each enable output equals its stored bit.
- R3: `mic_bias_oe` is 1 only while bit 1 is stored as 1. A 0 releases the pad to high impedance.
- R4: A 0-to-1 change of bit 4 or bit 5 enters ADC_INIT with the count at zero. The count advances on each `fs_strobe` cycle that carries no power-register write, or whose write changes neither START nor STOP. `adc_valid` rises the cycle after the INIT_SAMPLES-th counted strobe. It stays 1 while any ADC bit remains set.
- R5: A further 0-to-1 change of either ADC bit, during ADC_INIT or ADC_READY, drops `adc_valid` and restarts the count from zero.
- R6: A power write that leaves both ADC bits at 0 returns to ADC_IDLE. `adc_valid` then stays 0 regardless of strobes.
- R7: While `pdn_n` is low, all outputs are 0, and the stored bits and the error flag are cleared.
- R8: Writing 8'h00 to the power register turns every enable off but does not clear the error flag.
- R9: A power write with any of bits 7..1 set and bit 0 clear sets the error flag. The flag is read as bit 0 of `rd_data` with `rd_sel`=1, and drives `bias_err`. It is cleared only by a write with `wr_sel`=1 and `wr_data[0]`=1.
- R10: `clk_req` is 1 whenever any of bits 7..4 is stored as 1.
- R11: With `rd_sel`=0, `rd_data` shows the stored power bits exactly as written, including illegal bias combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| pdn_n | input | 1 | Active-low hardware power-down, asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 power register, 1 status |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 power register, 1 status |
| rd_data | output | 8 | Read data |
| fs_strobe | input | 1 | One-cycle pulse per audio sample period |
| en_vref | output | 1 | Reference bias enable |
| mic_bias_oe | output | 1 | Mic-bias pad drive enable (0 = high impedance) |
| en_mic_l | output | 1 | Left mic amp enable |
| en_mic_r | output | 1 | Right mic amp enable |
| en_adc_l | output | 1 | Left ADC enable |
| en_adc_r | output | 1 | Right ADC enable |
| en_dac_l | output | 1 | Left DAC enable |
| en_dac_r | output | 1 | Right DAC enable |
| adc_valid | output | 1 | ADC data valid, initialization finished |
| clk_req | output | 1 | External converter clocks required |
| bias_err | output | 1 | Sticky illegal bias setting flag |

## Verification
The assertions assume the following about the inputs:
- `fs_strobe` and `wr_en` are synchronous to `clk`.
- Checks that need reset history are disabled while `pdn_n` is low.
- Power-down is sampled as a level at clock edges.

The stimulus drives every input at the falling clock edge. It holds each write for exactly one cycle and pulses strobes one cycle high with a gap. It toggles `pdn_n` only away from the rising edge. A behavioural model in the bench tracks the stored bits, the flag and the window count, and is compared on every cycle.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
    localparam int PWR_W = 8;

    // Bit positions of the power register (software-visible map)
    localparam int B_VREF  = 0;
    localparam int B_MBIAS = 1;
    localparam int B_MIC_L = 2;
    localparam int B_MIC_R = 3;
    localparam int B_ADC_L = 4;
    localparam int B_ADC_R = 5;
    localparam int B_DAC_L = 6;
    localparam int B_DAC_R = 7;

    localparam logic [PWR_W-1:0] ADC_MASK = 8'h30;
    localparam logic [PWR_W-1:0] CLK_MASK = 8'hF0;

    typedef enum logic [1:0] {
        ADC_IDLE  = 2'd0,
        ADC_INIT  = 2'd1,
        ADC_READY = 2'd2
    } adc_state_t;
endpackage

// File: rtl/cpm_ctrl_reg.sv
module cpm_ctrl_reg
    import codec_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             pdn_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [PWR_W-1:0] wr_data,
    output logic [PWR_W-1:0] pwr_q,
    output logic             err_q,
    output logic             adc_start,
    output logic             adc_stop
);
    logic pwr_wr;
    logic bad_bias;
    logic err_clr;

    always_comb begin
        pwr_wr    = wr_en && !wr_sel;
        bad_bias  = (|wr_data[PWR_W-1:1]) && !wr_data[B_VREF];
        err_clr   = wr_en && wr_sel && wr_data[0];
        adc_start = pwr_wr && (|(wr_data & ~pwr_q & ADC_MASK));
        adc_stop  = pwr_wr && !(|(wr_data & ADC_MASK));
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            pwr_q <= '0;
        end else if (pwr_wr) begin
            pwr_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            err_q <= 1'b0;
        end else if (pwr_wr && bad_bias) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    // R2
    reg_store_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        pwr_wr |=> (pwr_q == $past(wr_data)));

    // R9
    bias_err_set_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (pwr_wr && bad_bias) |=> err_q);

    // R9
    bias_err_hold_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/cpm_adc_init.sv
module cpm_adc_init
    import codec_pwr_pkg::*;
#(
    parameter int INIT_SAMPLES = 1059
) (
    input  logic clk,
    input  logic pdn_n,
    input  logic fs_strobe,
    input  logic adc_start,
    input  logic adc_stop,
    output logic adc_ready
);
    localparam int CNT_W = $clog2(INIT_SAMPLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_SAMPLES - 1);

    adc_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge pdn_n) begin
        if (!pdn_n) begin
            state_q <= ADC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (adc_stop) begin
            state_d = ADC_IDLE;          // STOP
            cnt_d   = '0;
        end else if (adc_start) begin
            state_d = ADC_INIT;          // START
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ADC_IDLE:  cnt_d = '0;
                ADC_INIT: begin
                    if (fs_strobe) begin
                        if (cnt_q == LAST) begin
                            state_d = ADC_READY; // DONE
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ADC_READY: cnt_d = '0;
                default: begin
                    state_d = ADC_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        adc_ready = (state_q == ADC_READY);
    end

    // R6
    abort_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        adc_stop |=> (state_q == ADC_IDLE));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (adc_start && !adc_stop) |=> (state_q == ADC_INIT && cnt_q == '0));

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        (cnt_q <= LAST));
endmodule

// File: rtl/cpm_enable_map.sv
module cpm_enable_map
    import codec_pwr_pkg::*;
(
    input  logic             pdn_n,
    input  logic [PWR_W-1:0] pwr_q,
    input  logic             adc_ready,
    output logic [PWR_W-1:0] en,
    output logic             valid,
    output logic             clk_need
);
    always_comb begin
        en       = pdn_n ? pwr_q : '0;
        valid    = pdn_n && adc_ready && (|(pwr_q & ADC_MASK));
        clk_need = pdn_n && (|(pwr_q & CLK_MASK));
    end
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
    import codec_pwr_pkg::*;
#(
    parameter int INIT_SAMPLES = 1059
) (
    input  logic             clk,
    input  logic             pdn_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [PWR_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [PWR_W-1:0] rd_data,
    input  logic             fs_strobe,
    output logic             en_vref,
    output logic             mic_bias_oe,
    output logic             en_mic_l,
    output logic             en_mic_r,
    output logic             en_adc_l,
    output logic             en_adc_r,
    output logic             en_dac_l,
    output logic             en_dac_r,
    output logic             adc_valid,
    output logic             clk_req,
    output logic             bias_err
);
    logic [PWR_W-1:0] pwr_q;
    logic [PWR_W-1:0] en;
    logic             err_q;
    logic             adc_start;
    logic             adc_stop;
    logic             adc_ready;

    cpm_ctrl_reg u_reg (
        .clk       (clk),
        .pdn_n     (pdn_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .pwr_q     (pwr_q),
        .err_q     (err_q),
        .adc_start (adc_start),
        .adc_stop  (adc_stop)
    );

    cpm_adc_init #(.INIT_SAMPLES(INIT_SAMPLES)) u_init (
        .clk       (clk),
        .pdn_n     (pdn_n),
        .fs_strobe (fs_strobe),
        .adc_start (adc_start),
        .adc_stop  (adc_stop),
        .adc_ready (adc_ready)
    );

    cpm_enable_map u_map (
        .pdn_n     (pdn_n),
        .pwr_q     (pwr_q),
        .adc_ready (adc_ready),
        .en        (en),
        .valid     (adc_valid),
        .clk_need  (clk_req)
    );

    always_comb begin
        en_vref     = en[B_VREF];
        mic_bias_oe = en[B_MBIAS];
        en_mic_l    = en[B_MIC_L];
        en_mic_r    = en[B_MIC_R];
        en_adc_l    = en[B_ADC_L];
        en_adc_r    = en[B_ADC_R];
        en_dac_l    = en[B_DAC_L];
        en_dac_r    = en[B_DAC_R];
        bias_err    = err_q;
        rd_data     = rd_sel ? {{(PWR_W-1){1'b0}}, err_q} : pwr_q;
    end

    // R7
    always @(posedge clk) begin
        if (!pdn_n) begin
            pdn_off_chk: assert (en == '0 && !adc_valid && !clk_req && rd_data == '0);
        end
    end

    // R4
    valid_needs_adc_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        adc_valid |-> (en_adc_l || en_adc_r));

    // R10
    clk_req_chk: assert property (@(posedge clk) disable iff (!pdn_n)
        adc_valid |-> clk_req);
endmodule

// File: tb/codec_pwr_ctrl_tb.sv
module codec_pwr_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 1059;

    logic       clk = 1'b0;
    logic       pdn_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic       fs_strobe = 1'b0;
    logic [7:0] rd_data;
    logic en_vref, mic_bias_oe, en_mic_l, en_mic_r, en_adc_l, en_adc_r, en_dac_l, en_dac_r;
    logic adc_valid, clk_req, bias_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    logic [7:0] m_reg = 8'h00;
    bit         m_err = 1'b0;
    bit         m_init = 1'b0;
    bit         m_ready = 1'b0;
    int         m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    codec_pwr_ctrl #(.INIT_SAMPLES(N)) u_dut (
        .clk(clk), .pdn_n(pdn_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .fs_strobe(fs_strobe),
        .en_vref(en_vref), .mic_bias_oe(mic_bias_oe), .en_mic_l(en_mic_l), .en_mic_r(en_mic_r),
        .en_adc_l(en_adc_l), .en_adc_r(en_adc_r), .en_dac_l(en_dac_l), .en_dac_r(en_dac_r),
        .adc_valid(adc_valid), .clk_req(clk_req), .bias_err(bias_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!pdn_n) begin
            m_reg = 8'h00; m_err = 1'b0; m_init = 1'b0; m_ready = 1'b0; m_cnt = 0;
        end else begin
            if (wr_en && !wr_sel) begin
                if (wr_data[7:1] != 7'd0 && !wr_data[0]) m_err = 1'b1;
                if ((wr_data & 8'h30) == 8'h00) begin
                    m_init = 1'b0; m_ready = 1'b0; m_cnt = 0;
                end else if ((wr_data & ~m_reg & 8'h30) != 8'h00) begin
                    m_init = 1'b1; m_ready = 1'b0; m_cnt = 0;
                end else if (m_init && fs_strobe) begin
                    m_cnt++;
                    if (m_cnt == N) begin m_init = 1'b0; m_ready = 1'b1; end
                end
                m_reg = wr_data;
            end else begin
                if (wr_en && wr_sel && wr_data[0]) m_err = 1'b0;
                if (m_init && fs_strobe) begin
                    m_cnt++;
                    if (m_cnt == N) begin m_init = 1'b0; m_ready = 1'b1; end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!done) begin
            logic [7:0] e_reg;
            logic [7:0] got;
            e_reg = pdn_n ? m_reg : 8'h00;
            got = {en_dac_r, en_dac_l, en_adc_r, en_adc_l, en_mic_r, en_mic_l, mic_bias_oe, en_vref};
            chk("R2 enables", got, e_reg);
            chk("R3 mic_bias_oe", mic_bias_oe, e_reg[1]);
            chk("R4 adc_valid", adc_valid, pdn_n && m_ready && (m_reg & 8'h30) != 0);
            chk("R10 clk_req", clk_req, (e_reg & 8'hF0) != 0);
            chk("R9 bias_err", bias_err, pdn_n && m_err);
            chk("R11 rd_data", rd_data, rd_sel ? {7'd0, pdn_n && m_err} : e_reg);
        end
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fs_strobe = 1'b1;
            @(negedge clk); fs_strobe = 1'b0;
        end
    endtask

    task automatic settle();
        @(negedge clk); #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        pdn_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R1 adc_valid after reset", adc_valid, 0);
        chk("R1 clk_req after reset", clk_req, 0);

        // R3 mic-bias pad drive
        wr(0, 8'h03); settle();
        chk("R3 pad driven", mic_bias_oe, 1);
        wr(0, 8'h01); settle();
        chk("R3 pad released", mic_bias_oe, 0);

        // R10 DAC only needs clocks
        wr(0, 8'hC1); settle();
        chk("R10 clk_req with DACs", clk_req, 1);
        chk("R2 DAC enables", {en_dac_r, en_dac_l}, 2'b11);

        // R4 window length
        wr(0, 8'h11);
        strobes(N - 1); settle();
        chk("R4 valid before last strobe", adc_valid, 0);
        strobes(1); #2;
        chk("R4 valid after last strobe", adc_valid, 1);

        // R5 restart on second channel
        wr(0, 8'h31); settle();
        chk("R5 valid dropped on restart", adc_valid, 0);
        strobes(500);
        wr(0, 8'h21);
        strobes(N - 501); settle();
        chk("R5 count restarted", adc_valid, 0);
        strobes(1); #2;
        chk("R5 valid after restarted window", adc_valid, 1);

        // R6 abort
        wr(0, 8'h11); strobes(300);
        wr(0, 8'h01);
        strobes(N + 20); settle();
        chk("R6 valid after abort", adc_valid, 0);

        // R9 sticky error
        rd_sel = 1'b1;
        wr(0, 8'h10); settle();
        chk("R9 error set", rd_data, 8'h01);
        wr(1, 8'h00); settle();
        chk("R9 error kept by zero write", bias_err, 1);
        // R8 all-zero power write keeps flag
        wr(0, 8'h00); settle();
        chk("R8 enables off", {en_adc_l, en_vref}, 2'b00);
        chk("R8 flag kept", bias_err, 1);
        wr(1, 8'h01); settle();
        chk("R9 error cleared", rd_data, 8'h00);

        // R11 stored bits shown even when illegal
        rd_sel = 1'b0;
        wr(0, 8'h0C); settle();
        chk("R11 stored illegal bits", rd_data, 8'h0C);

        // R7 power-down pin
        wr(0, 8'hFF); strobes(10);
        @(negedge clk); pdn_n = 1'b0;
        #2;
        chk("R7 enables forced off", en_vref | en_dac_r | mic_bias_oe, 0);
        repeat (3) @(negedge clk);
        pdn_n = 1'b1; settle();
        chk("R7 register reset", rd_data, 8'h00);
        chk("R7 flag reset", bias_err, 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule